// File: doc/BRIEF.md
# Trap Vector and Level Selector

This block takes a pending trap and decides which execution mode handles it: the reset/error mode, hyperprivileged mode or privileged mode. From that decision it forms the handler fetch address and the address of the instruction after it. The trap-entry sequencer presents the present trap level, the trap type, the mode-status bits and the two vector base registers, then pulses a request. One clock later it reads the chosen mode, the trap type actually used for vectoring, the handler PC and NPC, and a flag that marks the unrecoverable error level.

The present privilege is hyperprivileged when the hypervisor bit is set. Otherwise it is privileged when the supervisor bit is set, and user when neither is set. A trap taken from user or privileged code normally targets privileged mode, and a trap taken from hyperprivileged code targets hyperprivileged mode. Several conditions override that target. The reset/error mode bit and the top two trap levels take precedence over everything else. A guest that is already nested too deeply receives a watchdog trap in hyperprivileged mode. Trap types of 384 and above always go to the hypervisor.

Top module: `trap_vec_sel`

## Requirements
- R1: Results are registered. `vld_o` is high in the cycle after each cycle with `req_i` high and low otherwise, and all other outputs hold their values while no request is taken.
- R2: If `red_i` is set, or `lvl_i` equals MAX_TL-1, the mode is reset/error (mode code 2) and the effective trap type is 5. This takes priority over the error-level check.
- R3: Without R2 and with `lvl_i` at or above MAX_TL, `err_o` is 1, the mode code is 3, and the effective trap type, PC and NPC are all zero. `err_o` is 0 for every other request.
- R4: Without R2/R3, if `lvl_i` exceeds MAX_PTL and the target is privileged (hypervisor bit clear), the mode is hyperprivileged (code 1) with effective trap type 2.
- R5: Without R2–R4, a request with the hypervisor bit set goes to hyperprivileged mode (code 1) and uses its own trap type.
- R6: Without R2–R5, a trap type of 384 or more goes to hyperprivileged mode (code 1) and uses its own trap type.
- R7: All other requests go to privileged mode (code 0) and use their own trap type.
- R8: In mode 2, PC = 0xFFF0000000 OR ((effective type << 5) AND 0xFF).
- R9: In mode 1, PC = (`htba_i` with bits 13:0 cleared) OR ((effective type << 5) AND 0x3FFF).
- R10: In mode 0, PC = (`tba_i` with bits 14:0 cleared) OR (bit 14 when `lvl_i`+1 > 1) OR ((type << 5) AND 0x3FFF).
- R11: Outside the error level, NPC = PC + 4.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Trap request strobe |
| lvl_i | input | TL_W | Current trap level |
| tt_i | input | TT_W | Trap type of the pending trap |
| red_i | input | 1 | Reset/error-mode status bit |
| hpriv_i | input | 1 | Hypervisor status bit |
| priv_i | input | 1 | Supervisor status bit |
| tba_i | input | ADDR_W | Privileged trap base address |
| htba_i | input | ADDR_W | Hyperprivileged trap base address |
| vld_o | output | 1 | Result valid, one cycle after request |
| mode_o | output | 2 | 0 privileged, 1 hyperprivileged, 2 reset/error, 3 error level |
| tt_o | output | TT_W | Effective trap type used for vectoring |
| pc_o | output | ADDR_W | Handler PC |
| npc_o | output | ADDR_W | Handler NPC |
| err_o | output | 1 | Error-level flag |

## Verification
The hardest cases to reach are the overlaps near the top of the trap-level range. There, the reset/error bit, the MAX_TL-1 level, the error level and the guest-watchdog threshold all compete, and only the priority order decides the outcome. The stimulus walks the level input through every value from MAX_PTL upward, including the out-of-range encodings above MAX_TL. It repeats this with each privilege combination and with the reset/error bit both set and clear. It also issues back-to-back requests and idle gaps, which checks that each registered result lines up with its own request and then holds.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
   typedef enum logic [1:0] {
      TVS_PRIV = 2'd0,
      TVS_HYP  = 2'd1,
      TVS_RED  = 2'd2,
      TVS_ERR  = 2'd3
   } tvs_mode_e;

   typedef enum logic [1:0] {
      LVL_USER = 2'd0,
      LVL_SUP  = 2'd1,
      LVL_HYP  = 2'd2
   } tvs_lvl_e;

   localparam int TVS_RED_TT = 5;
   localparam int TVS_WDOG_TT = 2;
   localparam int TVS_SLOT_SHIFT = 5;
endpackage

// File: rtl/tvs_level_decode.sv
module tvs_level_decode
   import tvs_pkg::*;
(
   input  logic     hpriv_i,
   input  logic     priv_i,
   output tvs_lvl_e cur_o,
   output logic     tgt_hyp_o
);
   always_comb begin
      if (hpriv_i)     cur_o = LVL_HYP;
      else if (priv_i) cur_o = LVL_SUP;
      else             cur_o = LVL_USER;
   end

   // user and supervisor both land in supervisor; only hypervisor stays put
   assign tgt_hyp_o = (cur_o == LVL_HYP);
endmodule

// File: rtl/tvs_mode_select.sv
module tvs_mode_select
   import tvs_pkg::*;
#(
   parameter int TL_W     = 3,
   parameter int TT_W     = 9,
   parameter int MAX_TL   = 6,
   parameter int MAX_PTL  = 2,
   parameter int HYP_TT_MIN = 384
) (
   input  logic [TL_W-1:0] lvl_i,
   input  logic [TT_W-1:0] tt_i,
   input  logic            red_i,
   input  logic            tgt_hyp_i,
   output tvs_mode_e       mode_o,
   output logic [TT_W-1:0] tt_o
);
   localparam int TOP_SAFE = MAX_TL - 1;

   logic at_red_lvl, at_err_lvl, guest_deep, hyp_type;

   assign at_red_lvl = (int'(lvl_i) == TOP_SAFE);
   assign at_err_lvl = (int'(lvl_i) >= MAX_TL);
   assign guest_deep = (int'(lvl_i) > MAX_PTL) && !tgt_hyp_i;
   assign hyp_type   = (int'(tt_i) >= HYP_TT_MIN);

   always_comb begin
      if (red_i || at_red_lvl) begin
         mode_o = TVS_RED;
         tt_o   = TT_W'(TVS_RED_TT);
      end else if (at_err_lvl) begin
         mode_o = TVS_ERR;
         tt_o   = '0;
      end else if (guest_deep) begin
         mode_o = TVS_HYP;
         tt_o   = TT_W'(TVS_WDOG_TT);
      end else if (tgt_hyp_i || hyp_type) begin
         mode_o = TVS_HYP;
         tt_o   = tt_i;
      end else begin
         mode_o = TVS_PRIV;
         tt_o   = tt_i;
      end
   end
endmodule

// File: rtl/tvs_vector_gen.sv
module tvs_vector_gen
   import tvs_pkg::*;
#(
   parameter int              ADDR_W     = 64,
   parameter int              TL_W       = 3,
   parameter int              TT_W       = 9,
   parameter int              HYP_ALIGN  = 14,
   parameter int              RED_OFF_W  = 8,
   parameter int              INSN_BYTES = 4,
   parameter logic [ADDR_W-1:0] RED_BASE = ADDR_W'(40'hFF_F000_0000)
) (
   input  tvs_mode_e         mode_i,
   input  logic [TT_W-1:0]   tt_i,
   input  logic [TL_W-1:0]   lvl_i,
   input  logic [ADDR_W-1:0] tba_i,
   input  logic [ADDR_W-1:0] htba_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o
);
   localparam int PRIV_ALIGN = HYP_ALIGN + 1;
   localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] HYP_MASK  = (ONE << HYP_ALIGN) - ONE;
   localparam logic [ADDR_W-1:0] PRIV_MASK = (ONE << PRIV_ALIGN) - ONE;
   localparam logic [ADDR_W-1:0] RED_MASK  = (ONE << RED_OFF_W) - ONE;
   localparam logic [ADDR_W-1:0] NEST_BIT  = ONE << HYP_ALIGN;
   localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(INSN_BYTES);

   logic [ADDR_W-1:0] slot, red_pc, hyp_pc, priv_pc;
   logic              nested;

   assign slot   = ADDR_W'(tt_i) << TVS_SLOT_SHIFT;
   // new trap level is lvl_i+1; it exceeds 1 whenever lvl_i is non-zero
   assign nested = (lvl_i != '0);

   assign red_pc  = RED_BASE | (slot & RED_MASK);
   assign hyp_pc  = (htba_i & ~HYP_MASK) | (slot & HYP_MASK);
   assign priv_pc = (tba_i & ~PRIV_MASK) | (nested ? NEST_BIT : '0) | (slot & HYP_MASK);

   always_comb begin
      unique case (mode_i)
         TVS_RED:  pc_o = red_pc;
         TVS_HYP:  pc_o = hyp_pc;
         TVS_PRIV: pc_o = priv_pc;
         default:  pc_o = '0;
      endcase
      npc_o = (mode_i == TVS_ERR) ? '0 : pc_o + STEP;
   end
endmodule

// File: rtl/trap_vec_sel.sv
module trap_vec_sel
   import tvs_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int TL_W       = 3,
   parameter int TT_W       = 9,
   parameter int MAX_TL     = 6,
   parameter int MAX_PTL    = 2,
   parameter int HYP_TT_MIN = 384,
   parameter int HYP_ALIGN  = 14,
   parameter int RED_OFF_W  = 8,
   parameter int INSN_BYTES = 4,
   parameter logic [ADDR_W-1:0] RED_BASE = ADDR_W'(40'hFF_F000_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [TL_W-1:0]   lvl_i,
   input  logic [TT_W-1:0]   tt_i,
   input  logic              red_i,
   input  logic              hpriv_i,
   input  logic              priv_i,
   input  logic [ADDR_W-1:0] tba_i,
   input  logic [ADDR_W-1:0] htba_i,
   output logic              vld_o,
   output logic [1:0]        mode_o,
   output logic [TT_W-1:0]   tt_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o,
   output logic              err_o
);
   generate
      if (MAX_PTL >= MAX_TL - 1) begin : g_bad_levels
         $error("MAX_PTL must sit below MAX_TL-1");
      end
      if ((1 << TL_W) <= MAX_TL) begin : g_bad_tlw
         $error("TL_W too narrow for MAX_TL");
      end
      if (TT_W + TVS_SLOT_SHIFT > HYP_ALIGN) begin : g_bad_ttw
         $error("trap type slot overflows the vector window");
      end
      if (ADDR_W <= HYP_ALIGN + 1) begin : g_bad_addr
         $error("ADDR_W too small");
      end
   endgenerate

   tvs_lvl_e          cur_lvl;
   logic              tgt_hyp;
   tvs_mode_e         mode_d;
   logic [TT_W-1:0]   tt_d;
   logic [ADDR_W-1:0] pc_d, npc_d;

   tvs_level_decode u_lvl (
      .hpriv_i   (hpriv_i),
      .priv_i    (priv_i),
      .cur_o     (cur_lvl),
      .tgt_hyp_o (tgt_hyp)
   );

   tvs_mode_select #(
      .TL_W(TL_W), .TT_W(TT_W), .MAX_TL(MAX_TL),
      .MAX_PTL(MAX_PTL), .HYP_TT_MIN(HYP_TT_MIN)
   ) u_sel (
      .lvl_i     (lvl_i),
      .tt_i      (tt_i),
      .red_i     (red_i),
      .tgt_hyp_i (tgt_hyp),
      .mode_o    (mode_d),
      .tt_o      (tt_d)
   );

   tvs_vector_gen #(
      .ADDR_W(ADDR_W), .TL_W(TL_W), .TT_W(TT_W), .HYP_ALIGN(HYP_ALIGN),
      .RED_OFF_W(RED_OFF_W), .INSN_BYTES(INSN_BYTES), .RED_BASE(RED_BASE)
   ) u_vec (
      .mode_i (mode_d),
      .tt_i   (tt_d),
      .lvl_i  (lvl_i),
      .tba_i  (tba_i),
      .htba_i (htba_i),
      .pc_o   (pc_d),
      .npc_o  (npc_d)
   );

   logic unused_lvl;
   assign unused_lvl = ^cur_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         mode_o <= '0;
         tt_o   <= '0;
         pc_o   <= '0;
         npc_o  <= '0;
         err_o  <= 1'b0;
      end else begin
         vld_o <= req_i;
         if (req_i) begin
            mode_o <= mode_d;
            tt_o   <= tt_d;
            pc_o   <= pc_d;
            npc_o  <= npc_d;
            err_o  <= (mode_d == TVS_ERR);
         end
      end
   end
endmodule

// File: rtl/trap_vec_sel_chk.sv
module trap_vec_sel_chk #(
   parameter int ADDR_W = 64,
   parameter int TL_W   = 3,
   parameter int TT_W   = 9,
   parameter int MAX_TL = 6,
   parameter int INSN_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic [TL_W-1:0]   lvl_i,
   input logic [TT_W-1:0]   tt_i,
   input logic              red_i,
   input logic              hpriv_i,
   input logic              priv_i,
   input logic [ADDR_W-1:0] tba_i,
   input logic [ADDR_W-1:0] htba_i,
   input logic              vld_o,
   input logic [1:0]        mode_o,
   input logic [TT_W-1:0]   tt_o,
   input logic [ADDR_W-1:0] pc_o,
   input logic [ADDR_W-1:0] npc_o,
   input logic              err_o
);
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> vld_o);
   a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !vld_o);
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> ($stable(pc_o) && $stable(mode_o) && $stable(tt_o) && $stable(err_o)));
   a_r2_red_pick: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && red_i) |=> (mode_o == 2'd2 && int'(tt_o) == 5 && !err_o));
   a_r3_err_level: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !red_i && int'(lvl_i) >= MAX_TL) |=> (err_o && mode_o == 2'd3 && pc_o == '0));
   a_r3_err_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && err_o) |-> (mode_o == 2'd3));
   a_r9_hyp_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && mode_o == 2'd1) |-> (pc_o[4:0] == 5'd0));
   a_r11_npc: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && !err_o) |-> (npc_o == pc_o + ADDR_W'(INSN_BYTES)));
endmodule

bind trap_vec_sel trap_vec_sel_chk #(
   .ADDR_W(ADDR_W), .TL_W(TL_W), .TT_W(TT_W), .MAX_TL(MAX_TL), .INSN_BYTES(INSN_BYTES)
) chk_i (.*);

// File: tb/trap_vec_sel_tb_top.sv
module trap_vec_sel_tb_top;
   localparam int AW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic [2:0]    lvl_i = '0;
   logic [8:0]    tt_i = '0;
   logic          red_i = 1'b0, hpriv_i = 1'b0, priv_i = 1'b0;
   logic [AW-1:0] tba_i = '0, htba_i = '0;
   logic          vld_o, err_o;
   logic [1:0]    mode_o;
   logic [8:0]    tt_o;
   logic [AW-1:0] pc_o, npc_o;

   always #2.5 clk = ~clk;

   trap_vec_sel dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .lvl_i(lvl_i), .tt_i(tt_i),
      .red_i(red_i), .hpriv_i(hpriv_i), .priv_i(priv_i), .tba_i(tba_i),
      .htba_i(htba_i), .vld_o(vld_o), .mode_o(mode_o), .tt_o(tt_o),
      .pc_o(pc_o), .npc_o(npc_o), .err_o(err_o)
   );

   typedef struct {
      logic [1:0]    mode;
      logic [8:0]    tt;
      logic [AW-1:0] pc;
      logic [AW-1:0] npc;
      logic          err;
      string         tag_sel;
      string         tag_vec;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 0;
   bit   seen = 0;
   logic [AW-1:0] last_pc;
   logic [1:0]    last_mode;

   task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // expected result from the requirement text
   function automatic exp_t model(input logic [2:0] lvl, input logic [8:0] tt, input bit red,
                                  input bit hp, input bit pv, input logic [AW-1:0] tba,
                                  input logic [AW-1:0] htba);
      exp_t e;
      logic [AW-1:0] sl;
      e.err = 0;
      if (red || lvl == 3'd5) begin
         e.mode = 2; e.tt = 9'd5; e.tag_sel = "R2"; e.tag_vec = "R8";
      end else if (lvl >= 3'd6) begin
         e.mode = 3; e.tt = 0; e.err = 1; e.tag_sel = "R3"; e.tag_vec = "R3";
      end else if (lvl > 3'd2 && !hp) begin
         e.mode = 1; e.tt = 9'd2; e.tag_sel = "R4"; e.tag_vec = "R9";
      end else if (hp) begin
         e.mode = 1; e.tt = tt; e.tag_sel = "R5"; e.tag_vec = "R9";
      end else if (tt >= 9'd384) begin
         e.mode = 1; e.tt = tt; e.tag_sel = "R6"; e.tag_vec = "R9";
      end else begin
         e.mode = 0; e.tt = tt; e.tag_sel = "R7"; e.tag_vec = "R10";
      end
      sl = {46'd0, e.tt, 9'd0} >> 4;
      case (e.mode)
         2'd2: e.pc = 64'h0000_00FF_F000_0000 | (sl & 64'hFF);
         2'd1: e.pc = {htba[AW-1:14], 14'd0} | (sl & 64'h3FFF);
         2'd0: e.pc = {tba[AW-1:15], 15'd0} | ((lvl + 4'd1 > 4'd1) ? 64'h4000 : 64'h0) | (sl & 64'h3FFF);
         default: e.pc = '0;
      endcase
      e.npc = e.err ? '0 : e.pc + 64'd4;
      if (pv) e.tag_sel = e.tag_sel;
      return e;
   endfunction

   task automatic drive(input logic [2:0] lvl, input logic [8:0] tt, input bit red,
                        input bit hp, input bit pv, input logic [AW-1:0] tba,
                        input logic [AW-1:0] htba);
      lvl_i = lvl; tt_i = tt; red_i = red; hpriv_i = hp; priv_i = pv;
      tba_i = tba; htba_i = htba; req_i = 1'b1;
      exp_q.push_back(model(lvl, tt, red, hp, pv, tba, htba));
      @(negedge clk);
      req_i = 1'b0;
   endtask

   // monitor: sample away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (vld_o) begin
            if (exp_q.size() == 0) begin
               chk(0, "R1", {63'd0, vld_o}, 64'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(mode_o == e.mode, e.tag_sel, {62'd0, mode_o}, {62'd0, e.mode});
               chk(tt_o == e.tt, e.tag_sel, {55'd0, tt_o}, {55'd0, e.tt});
               chk(err_o == e.err, "R3", {63'd0, err_o}, {63'd0, e.err});
               chk(pc_o == e.pc, e.tag_vec, pc_o, e.pc);
               chk(npc_o == e.npc, e.err ? "R3" : "R11", npc_o, e.npc);
               last_pc = pc_o; last_mode = mode_o; seen = 1;
            end
         end else if (seen) begin
            // R1: idle cycle keeps prior result
            chk(pc_o == last_pc && mode_o == last_mode, "R1", pc_o, last_pc);
         end
      end
   end

   localparam logic [AW-1:0] TBA  = 64'h1234_5678_9ABC_DEF0;
   localparam logic [AW-1:0] HTBA = 64'h0000_8000_4000_7FFF;

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset values
      chk(vld_o == 0 && err_o == 0 && mode_o == 0 && tt_o == 0, "R12", {63'd0, vld_o}, 64'd0);
      chk(pc_o == 0 && npc_o == 0, "R12", pc_o, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      drive(3'd0, 9'h024, 0, 0, 0, TBA, HTBA);   // R7 user, tl0, no nest bit
      drive(3'd1, 9'h030, 0, 0, 1, TBA, HTBA);   // R10 nest bit
      drive(3'd2, 9'h17F, 0, 0, 0, TBA, HTBA);   // R7 type 383, tl at MAX_PTL
      drive(3'd0, 9'h180, 0, 0, 1, TBA, HTBA);   // R6 type 384
      drive(3'd0, 9'h1FF, 0, 0, 0, TBA, HTBA);   // R6 top type
      repeat (3) @(negedge clk);                  // R1 idle hold
      drive(3'd0, 9'h010, 0, 1, 0, TBA, HTBA);   // R5
      drive(3'd3, 9'h041, 0, 0, 1, TBA, HTBA);   // R4 watchdog
      drive(3'd4, 9'h041, 0, 0, 0, TBA, HTBA);   // R4 from user
      drive(3'd3, 9'h041, 0, 1, 0, TBA, HTBA);   // R5 hyp deep, no watchdog
      drive(3'd5, 9'h100, 0, 0, 1, TBA, HTBA);   // R2 MAX_TL-1
      drive(3'd0, 9'h068, 1, 1, 0, TBA, HTBA);   // R2 red bit
      drive(3'd6, 9'h068, 0, 1, 0, TBA, HTBA);   // R3 error level
      @(negedge clk);
      drive(3'd7, 9'h068, 0, 0, 0, TBA, HTBA);   // R3 above error level
      drive(3'd6, 9'h068, 1, 0, 0, TBA, HTBA);   // R2 priority over R3
      drive(3'd1, 9'h0C0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, HTBA); // R10
      drive(3'd2, 9'h1A5, 0, 1, 1, TBA, 64'hFFFF_FFFF_FFFF_FFFF);  // R9
      for (int l = 0; l < 8; l++) begin
         for (int m = 0; m < 3; m++) begin
            drive(3'(l), 9'(37 * l + 100 * m), 0, m == 2, m == 1, TBA ^ 64'(l), HTBA + 64'(m));
         end
      end
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R1", 64'(exp_q.size()), 64'd0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL R1 watchdog actual=%h expected=%h", 64'd0, 64'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end
endmodule